// File: doc/BRIEF.md
# Serial Write-Only Control Register Port

This block is the device side of a three-wire control link: an active-low select, a serial clock and a serial data line. A host sends a 16-bit write frame, and the block uses it to update one register in a small bank of 8-bit control registers. The frame carries a two-bit device address, a direction flag, a five-bit register index and one data byte. The block has no read path. The host can learn nothing back through this port.

The three serial lines are brought into the system clock domain through two-flop synchronisers. Edges are then detected in that domain, and the block counts the bits shifted in while select is low. When select rises, the frame is checked. The register is written only if all of these hold:

- exactly 16 bits were received;
- the device address matches;
- the direction flag says write;
- the register index exists;
- the device is powered (`pdn_n` high) and its master clock is present (`mclk_ok` high).

While `pdn_n` is low, the whole bank is held at its default values. Bit 0 of register 0 is a soft timing-reset control. It powers up at 1, and `timing_reset` is high whenever that bit is 0.

Top module: `ctl_wport`

## Requirements
- R1: A frame is sent MSB first in this order: bit 15 = device-address high bit, bit 14 = device-address low bit, bit 13 = direction, bits 12..8 = register index, bits 7..0 = data. An accepted frame replaces the indexed register with the data byte, and no other register changes.
- R2: A frame is ignored unless bit 15 is 1 and bit 14 equals the `cad0` input.
- R3: A frame whose direction bit (bit 13) is 0 changes no register.
- R4: A write is committed only after `cs_n` rises. With all 16 bits shifted in and `cs_n` still low, the bank is unchanged.
- R5: A frame is committed only if exactly 16 rising serial-clock edges fell within the low period of `cs_n`. Shorter and longer frames are discarded. The bit count restarts each time `cs_n` falls.
- R6: While `pdn_n` is low, every register holds its default (register 0 = 8'h01, all others = 8'h00), and frames are ignored.
- R7: While `mclk_ok` is low, frames are ignored.
- R8: A frame addressed to an index at or above the number of registers (8 by default) is accepted on the link but changes no register.
- R9: `timing_reset` is high exactly while bit 0 of register 0 is 0. Writing register 0 leaves the other registers unchanged. Powering down drives `timing_reset` low.
- R10: Synchronous `rst` returns every register to its default value.
- R11: An accepted write is visible on `reg_flat` four system-clock edges after `cs_n` rises. This assumes the system clock runs at least four times faster than `sclk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pdn_n | input | 1 | Power-down, active low; holds the bank at its defaults |
| mclk_ok | input | 1 | Master clock present; writes are ignored while low |
| cad0 | input | 1 | Level that device-address bit 14 must match |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock; data is sampled on its rising edge |
| sdi | input | 1 | Serial data |
| reg_flat | output | NUM_REGS*8 | Register bank, with register i at bits [8i+7:8i] |
| timing_reset | output | 1 | High while the soft timing-reset bit is 0 |

## Verification
The bench targets these corner cases, each paired with the failure it would expose:

- **Commit timing.** A frame is held with select still low after 16 bits. A design that commits on the sixteenth edge would change the register early.
- **Frame length.** Frames one bit short and one bit long are sent. A counter that neither saturates nor restarts on select fall would accept one of them.
- **Frame filtering.** Frames with a wrong device address, a read direction flag, an unimplemented index, a missing master clock or active power-down must all leave the bank untouched. A gating term left out would corrupt a register.
- **Soft timing-reset bit.** Register 0 is cleared and then set again, and `timing_reset` must follow the bit in the expected polarity. An inverted or misplaced bit shows up directly.

// File: rtl/cwp_pkg.sv
package cwp_pkg;

    localparam int FRAME_BITS = 16;
    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 8;
    localparam int CNT_W      = $clog2(FRAME_BITS + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_BITS + 1);

    // location of the soft timing-reset control bit
    localparam int TRST_REG = 0;
    localparam int TRST_BIT = 0;

    typedef struct packed {
        logic              dev_hi;
        logic              dev_lo;
        logic              is_write;
        logic [ADDR_W-1:0] idx;
        logic [DATA_W-1:0] data;
    } frame_t;

    function automatic logic [DATA_W-1:0] reg_default(input int index);
        logic [DATA_W-1:0] v;
        v = '0;
        if (index == TRST_REG) v[TRST_BIT] = 1'b1;
        return v;
    endfunction

    function automatic logic frame_for_me(input frame_t f, input logic cad);
        return f.dev_hi && (f.dev_lo == cad) && f.is_write;
    endfunction

endpackage

// File: rtl/cwp_sync.sv
module cwp_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/cwp_rx.sv
module cwp_rx
    import cwp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cs_n_s,
    input  logic   sclk_s,
    input  logic   sdi_s,
    output logic   commit,
    output frame_t frm
);
    logic                  cs_q;
    logic                  sclk_q;
    logic [CNT_W-1:0]      nbits;
    logic [FRAME_BITS-1:0] shreg;
    logic                  sel_fall;
    logic                  sel_rise;
    logic                  bit_edge;

    always_comb begin
        sel_fall = cs_q && !cs_n_s;
        sel_rise = !cs_q && cs_n_s;
        bit_edge = !cs_n_s && sclk_s && !sclk_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q   <= 1'b1;
            sclk_q <= 1'b1;
            nbits  <= '0;
            shreg  <= '0;
            commit <= 1'b0;
        end else begin
            cs_q   <= cs_n_s;
            sclk_q <= sclk_s;
            commit <= sel_rise && (nbits == CNT_FULL);
            if (sel_fall) begin
                nbits <= '0;
                shreg <= '0;
            end else if (bit_edge) begin
                shreg <= {shreg[FRAME_BITS-2:0], sdi_s};
                if (nbits != CNT_SAT) nbits <= nbits + 1'b1;
            end
        end
    end

    assign frm = frame_t'(shreg);
endmodule

// File: rtl/cwp_regbank.sv
module cwp_regbank
    import cwp_pkg::*;
#(
    parameter int NUM_REGS = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       pdn_n,
    input  logic                       mclk_ok,
    input  logic                       cad0,
    input  logic                       commit,
    input  frame_t                     frm,
    output logic [NUM_REGS*DATA_W-1:0] reg_flat
);
    logic accept;

    always_comb begin
        accept = commit && pdn_n && mclk_ok && frame_for_me(frm, cad0)
                 && (int'(frm.idx) < NUM_REGS);
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [DATA_W-1:0] val;

        always_ff @(posedge clk) begin
            if (rst || !pdn_n) begin
                val <= reg_default(g);
            end else if (accept && (int'(frm.idx) == g)) begin
                val <= frm.data;
            end
        end

        assign reg_flat[g*DATA_W +: DATA_W] = val;
    end
endmodule

// File: rtl/ctl_wport.sv
module ctl_wport
    import cwp_pkg::*;
#(
    parameter int NUM_REGS = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       pdn_n,
    input  logic                       mclk_ok,
    input  logic                       cad0,
    input  logic                       cs_n,
    input  logic                       sclk,
    input  logic                       sdi,
    output logic [NUM_REGS*DATA_W-1:0] reg_flat,
    output logic                       timing_reset
);
    logic [2:0] line_s;
    logic       frm_commit;
    frame_t     frm_data;

    cwp_sync #(.W(3), .RST_VAL(3'b110)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({cs_n, sclk, sdi}),
        .q   (line_s)
    );

    cwp_rx u_rx (
        .clk    (clk),
        .rst    (rst),
        .cs_n_s (line_s[2]),
        .sclk_s (line_s[1]),
        .sdi_s  (line_s[0]),
        .commit (frm_commit),
        .frm    (frm_data)
    );

    cwp_regbank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .pdn_n    (pdn_n),
        .mclk_ok  (mclk_ok),
        .cad0     (cad0),
        .commit   (frm_commit),
        .frm      (frm_data),
        .reg_flat (reg_flat)
    );

    assign timing_reset = ~reg_flat[TRST_REG*DATA_W + TRST_BIT];
endmodule

// File: rtl/cwp_chk.sv
module cwp_chk
    import cwp_pkg::*;
#(
    parameter int NUM_REGS = 8
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       pdn_n,
    input logic                       mclk_ok,
    input logic                       cad0,
    input logic                       cs_n,
    input logic [NUM_REGS*DATA_W-1:0] reg_flat,
    input logic                       timing_reset,
    input logic                       frm_commit,
    input frame_t                     frm_data
);
    localparam int BANK_W = NUM_REGS * DATA_W;

    function automatic logic [BANK_W-1:0] bank_defaults();
        logic [BANK_W-1:0] v;
        for (int i = 0; i < NUM_REGS; i++) v[i*DATA_W +: DATA_W] = reg_default(i);
        return v;
    endfunction

    localparam logic [BANK_W-1:0] DEFAULTS = bank_defaults();

    logic [2:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst) since_rst <= '0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 1'b1;
    end

    // R6: power-down forces the defaults
    p_pdn_defaults_r6: assert property (@(posedge clk) disable iff (rst)
        !pdn_n |=> (reg_flat == DEFAULTS));

    // R9: power-down releases the timing reset
    p_pdn_treset_low_r9: assert property (@(posedge clk) disable iff (rst)
        !pdn_n |=> !timing_reset);

    // R7: no master clock, no change
    p_no_mclk_stable_r7: assert property (@(posedge clk) disable iff (rst)
        (pdn_n && !mclk_ok) |=> $stable(reg_flat));

    // R2: wrong device address
    p_dev_mismatch_r2: assert property (@(posedge clk) disable iff (rst)
        (frm_commit && pdn_n && (!frm_data.dev_hi || (frm_data.dev_lo != cad0)))
        |=> $stable(reg_flat));

    // R3: read direction ignored
    p_read_ignored_r3: assert property (@(posedge clk) disable iff (rst)
        (frm_commit && pdn_n && !frm_data.is_write) |=> $stable(reg_flat));

    // R8: unimplemented index
    p_unimpl_idx_r8: assert property (@(posedge clk) disable iff (rst)
        (frm_commit && pdn_n && (int'(frm_data.idx) >= NUM_REGS)) |=> $stable(reg_flat));

    // R4: a bank change needs select high four edges earlier
    p_commit_after_cs_r4: assert property (@(posedge clk) disable iff (rst)
        ((since_rst >= 3'd5) && pdn_n && $past(pdn_n) && !$stable(reg_flat))
        |-> $past(cs_n, 4));
endmodule

bind ctl_wport cwp_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .pdn_n        (pdn_n),
    .mclk_ok      (mclk_ok),
    .cad0         (cad0),
    .cs_n         (cs_n),
    .reg_flat     (reg_flat),
    .timing_reset (timing_reset),
    .frm_commit   (frm_commit),
    .frm_data     (frm_data)
);

// File: tb/tb_ctl_wport.sv
`timescale 1ns/100ps
module tb_ctl_wport;
    localparam int NREG = 8;
    localparam int NV   = 14;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              pdn_n = 1'b1;
    logic              mclk_ok = 1'b1;
    logic              cad0 = 1'b0;
    logic              cs_n = 1'b1;
    logic              sclk = 1'b1;
    logic              sdi = 1'b0;
    logic [NREG*8-1:0] reg_flat;
    logic              timing_reset;

    int checks = 0;
    int fails  = 0;
    logic [7:0] mdl [NREG];

    ctl_wport #(.NUM_REGS(NREG)) dut (
        .clk(clk), .rst(rst), .pdn_n(pdn_n), .mclk_ok(mclk_ok), .cad0(cad0),
        .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .reg_flat(reg_flat), .timing_reset(timing_reset)
    );

    always #2.5 clk = ~clk;

    // vector: {frame[15:0], nbits[4:0], pdn_n, mclk_ok, cad0}
    localparam logic [23:0] VECS [NV] = '{
        {1'b1,1'b0,1'b1,5'd1, 8'hA5, 5'd16,1'b1,1'b1,1'b0}, // R1 plain write
        {1'b1,1'b1,1'b1,5'd2, 8'h3C, 5'd16,1'b1,1'b1,1'b1}, // R2 cad0=1 match
        {1'b1,1'b0,1'b1,5'd3, 8'hFF, 5'd16,1'b1,1'b1,1'b1}, // R2 low bit mismatch
        {1'b0,1'b0,1'b1,5'd3, 8'h77, 5'd16,1'b1,1'b1,1'b0}, // R2 high bit zero
        {1'b1,1'b0,1'b0,5'd4, 8'h55, 5'd16,1'b1,1'b1,1'b0}, // R3 read flag
        {1'b1,1'b0,1'b1,5'd5, 8'h11, 5'd15,1'b1,1'b1,1'b0}, // R5 short
        {1'b1,1'b0,1'b1,5'd5, 8'h22, 5'd17,1'b1,1'b1,1'b0}, // R5 long
        {1'b1,1'b0,1'b1,5'd6, 8'h66, 5'd16,1'b1,1'b0,1'b0}, // R7 no mclk
        {1'b1,1'b0,1'b1,5'd20,8'h99, 5'd16,1'b1,1'b1,1'b0}, // R8 unimplemented
        {1'b1,1'b0,1'b1,5'd7, 8'h81, 5'd16,1'b1,1'b1,1'b0}, // R1 top register
        {1'b1,1'b0,1'b1,5'd0, 8'h00, 5'd16,1'b1,1'b1,1'b0}, // R9 clear trst bit
        {1'b1,1'b0,1'b1,5'd0, 8'h01, 5'd16,1'b1,1'b1,1'b0}, // R9 set trst bit
        {1'b1,1'b0,1'b1,5'd1, 8'hEE, 5'd16,1'b0,1'b1,1'b0}, // R6 power-down
        {1'b1,1'b0,1'b1,5'd5, 8'h5A, 5'd16,1'b1,1'b1,1'b0}  // R5 full frame after discards
    };

    function automatic logic [NREG*8-1:0] mdl_flat();
        logic [NREG*8-1:0] v;
        for (int i = 0; i < NREG; i++) v[i*8 +: 8] = mdl[i];
        return v;
    endfunction

    task automatic mdl_reset();
        for (int i = 0; i < NREG; i++) mdl[i] = (i == 0) ? 8'h01 : 8'h00;
    endtask

    task automatic chk(input string req, input logic [NREG*8-1:0] act,
                       input logic [NREG*8-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic shift_bits(input logic [15:0] f, input int n);
        cs_n = 1'b0;
        #40;
        for (int i = 0; i < n; i++) begin
            sclk = 1'b0;
            sdi  = (i < 16) ? f[15-i] : 1'b1;
            #20;
            sclk = 1'b1;
            #20;
        end
        #20;
    endtask

    task automatic raise_and_wait();
        cs_n = 1'b1;
        repeat (4) @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        mdl_reset();
        repeat (4) @(posedge clk);
        #1;
        rst = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk("R10 reset bank", reg_flat, mdl_flat());
        chk("R9 reset trst", {{(NREG*8-1){1'b0}}, timing_reset}, '0);

        for (int v = 0; v < NV; v++) begin
            logic [15:0] f;
            int          n;
            f       = VECS[v][23:8];
            n       = int'(VECS[v][7:3]);
            pdn_n   = VECS[v][2];
            mclk_ok = VECS[v][1];
            cad0    = VECS[v][0];
            shift_bits(f, n);
            raise_and_wait();
            if (!pdn_n) mdl_reset();
            else if (mclk_ok && n == 16 && f[15] && f[14] == cad0 && f[13]
                     && int'(f[12:8]) < NREG)
                mdl[f[12:8]] = f[7:0];
            chk($sformatf("R1/R2/R3/R5/R6/R7/R8/R11 vector %0d", v), reg_flat, mdl_flat());
            chk($sformatf("R9 trst vector %0d", v),
                {{(NREG*8-1){1'b0}}, timing_reset}, {{(NREG*8-1){1'b0}}, ~mdl[0][0]});
            pdn_n   = 1'b1;
            mclk_ok = 1'b1;
            #60;
        end

        // R4: all 16 bits in, select still low
        cad0 = 1'b0;
        shift_bits({1'b1,1'b0,1'b1,5'd2,8'h44}, 16);
        repeat (10) @(posedge clk);
        #1;
        chk("R4 before select rise", reg_flat, mdl_flat());
        raise_and_wait();
        mdl[2] = 8'h44;
        chk("R4 after select rise", reg_flat, mdl_flat());
        #60;

        // R9: clearing the trst bit leaves the others alone
        shift_bits({1'b1,1'b0,1'b1,5'd0,8'hF0}, 16);
        raise_and_wait();
        mdl[0] = 8'hF0;
        chk("R9 reg0 write bank", reg_flat, mdl_flat());
        chk("R9 trst high", {{(NREG*8-1){1'b0}}, timing_reset}, {{(NREG*8-1){1'b0}}, 1'b1});

        // R10: synchronous reset mid-run
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
        mdl_reset();
        chk("R10 reset mid-run", reg_flat, mdl_flat());

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule